// File: doc/BRIEF.md
# Stereo Audio High-Pass Filter with Polarity Control

The block removes DC and low-frequency content from a stereo stream of decimated converter samples. Each channel has its own filter state and its own strobe. Each sample is either passed through unchanged, filtered by a single first-order section with a fixed corner of about 3.7 Hz, or filtered by two cascaded first-order sections. That cascade is second order, and its corner comes from a 3-bit code and from the sample-rate group. A per-channel polarity inverter sits at the output.

Both channels share the control inputs. The caller holds the enable high for normal operation, which is the state it should drive out of reset. Each output strobe follows its input strobe by exactly two clock cycles. Changing the filter mode, the corner code or the rate code clears all filter state, so a change of settings does not produce a transient.

Top module: `audio_hpf`

## Requirements
- R1: While `hpf_en` is 0, each accepted sample reaches the output unfiltered, after the polarity stage, and the filter state is held at zero.
- R2: With `hpf_en`=1 and `hpf_mode`=0, each channel applies one section y = clamp18(x - xprev + floor(K*yprev / 16384)) with K = 16376. xprev and yprev are that channel's previous section input and output.
- R3: With `hpf_en`=1 and `hpf_mode`=1, two such sections are cascaded and share one coefficient K = 16384 - (W >> s). W is round(2*pi*f*16384/8000), where f is 82, 102, 131, 163, 204, 261, 327 or 408 for `cut_code` 0 to 7.
- R4: The shift s selects the sample-rate group from `sr_code[2:1]`: 00 gives s=2 (32-48 kHz), 01 gives s=1 (16-24 kHz), and 10 or 11 give s=0 (8-12 kHz).
- R5: When `inv_l` or `inv_r` is 1, that channel's output is negated. A value of -32768 becomes +32767 and does not wrap.
- R6: A change in any of `hpf_mode`, `cut_code` or `sr_code` clears every filter state register of both channels. The next sample's sections therefore start from zero history.
- R7: Each output strobe is high exactly two cycles after its own input strobe and at no other time. Left and right stay aligned when strobed together.
- R8: After reset both output strobes are 0, both output samples are 0 and all filter state is zero.
- R9: The filter result is saturated to the 16-bit signed range before the polarity stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpf_en | input | 1 | Filter enable (0 = bypass) |
| hpf_mode | input | 1 | 0 = fixed low corner, first order; 1 = selectable corner, second order |
| cut_code | input | 3 | Corner selection in mode 1 |
| sr_code | input | 3 | Declared sample-rate code |
| inv_l | input | 1 | Left polarity invert |
| inv_r | input | 1 | Right polarity invert |
| l_valid_i | input | 1 | Left sample strobe |
| l_data_i | input | 16 | Left signed sample |
| r_valid_i | input | 1 | Right sample strobe |
| r_data_i | input | 16 | Right signed sample |
| l_valid_o | output | 1 | Left output strobe |
| l_data_o | output | 16 | Left filtered sample |
| r_valid_o | output | 1 | Right output strobe |
| r_data_o | output | 16 | Right filtered sample |

## Verification
A wrong section state cannot stay hidden for long. It appears in the output of the very next strobed sample on that channel, two cycles after that sample's strobe, because every result depends on the previous input and output. A state that survives a settings change shows up as a first output that differs from the input it follows. A wrong coefficient or group shift shows up from the second sample after a clear onward. A broken strobe pipeline shows up at once, as a strobe one cycle early or late.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  localparam int FRAC = 14;
  localparam int ONE = 1 << FRAC;
  localparam int KFIX = 16376;
  localparam int XW = 48;

  function automatic logic signed [XW-1:0] clamp_w(input logic signed [XW-1:0] v, input int w);
    logic signed [XW-1:0] hi, lo;
    hi = (48'sd1 <<< (w - 1)) - 48'sd1;
    lo = -hi - 48'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic signed [XW-1:0] negate_sat(input logic signed [XW-1:0] v, input int w);
    logic signed [XW-1:0] lo;
    lo = -(48'sd1 <<< (w - 1));
    if (v == lo) return -lo - 48'sd1;
    return -v;
  endfunction

  // one first-order high-pass step in 2.14 fixed point
  function automatic logic signed [XW-1:0] sec_step(input logic signed [XW-1:0] x,
      input logic signed [XW-1:0] xp, input logic signed [XW-1:0] yp,
      input logic signed [XW-1:0] k, input int w);
    logic signed [XW-1:0] prod;
    prod = k * yp;
    return clamp_w(x - xp + (prod >>> FRAC), w);
  endfunction
endpackage

// File: rtl/hpf_coef.sv
module hpf_coef #(
  parameter int CW = 16
) (
  input  logic [2:0]           cut,
  input  logic [2:0]           sr,
  output logic signed [CW-1:0] k_o
);
  import hpf_pkg::*;

  function automatic logic [12:0] base_w(input logic [2:0] c);
    case (c)
      3'd0: return 13'd1055;
      3'd1: return 13'd1313;
      3'd2: return 13'd1686;
      3'd3: return 13'd2097;
      3'd4: return 13'd2625;
      3'd5: return 13'd3359;
      3'd6: return 13'd4208;
      default: return 13'd5250;
    endcase
  endfunction

  logic [1:0]  grp_shift;
  logic [12:0] w_eff;

  always_comb begin
    case (sr[2:1])
      2'b00:   grp_shift = 2'd2;
      2'b01:   grp_shift = 2'd1;
      default: grp_shift = 2'd0;
    endcase
    w_eff = base_w(cut) >> grp_shift;
    k_o = CW'(ONE - {19'd0, w_eff});
  end
endmodule

// File: rtl/hpf_channel.sv
module hpf_channel #(
  parameter int DW = 16,
  parameter int GUARD = 2,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 en,
  input  logic                 mode,
  input  logic signed [CW-1:0] k_sel,
  input  logic                 clr,
  input  logic                 pol,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  import hpf_pkg::*;
  localparam int IW = DW + GUARD;
  localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] SMAX = ~SMIN;

  logic signed [IW-1:0] xa_q, ya_q, xb_q, yb_q, acc_q;
  logic                 v1_q;
  logic                 clr_a, clr_b;
  logic signed [XW-1:0] x_w, xa_e, ya_e, xb_e, yb_e, k_a, k_b, sa_w, sb_w, sat_w, pol_w;
  logic signed [IW-1:0] filt_w;

  assign clr_a = clr || !en;
  assign clr_b = clr_a || !mode;

  always_comb begin
    x_w  = XW'(in_data);
    xa_e = clr_a ? '0 : XW'(xa_q);
    ya_e = clr_a ? '0 : XW'(ya_q);
    xb_e = clr_b ? '0 : XW'(xb_q);
    yb_e = clr_b ? '0 : XW'(yb_q);
    k_b  = XW'(k_sel);
    k_a  = mode ? k_b : XW'(KFIX);
    sa_w = sec_step(x_w, xa_e, ya_e, k_a, IW);
    sb_w = sec_step(sa_w, xb_e, yb_e, k_b, IW);
    if (!en)       filt_w = x_w[IW-1:0];
    else if (mode) filt_w = sb_w[IW-1:0];
    else           filt_w = sa_w[IW-1:0];
    sat_w = clamp_w(XW'(acc_q), DW);
    pol_w = pol ? negate_sat(sat_w, DW) : sat_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xa_q <= '0; ya_q <= '0; xb_q <= '0; yb_q <= '0;
      acc_q <= '0; v1_q <= 1'b0;
      out_valid <= 1'b0; out_data <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        acc_q <= filt_w;
        xa_q  <= clr_a ? '0 : x_w[IW-1:0];
        ya_q  <= clr_a ? '0 : sa_w[IW-1:0];
        xb_q  <= clr_b ? '0 : sa_w[IW-1:0];
        yb_q  <= clr_b ? '0 : sb_w[IW-1:0];
      end else begin
        xa_q <= xa_e[IW-1:0]; ya_q <= ya_e[IW-1:0];
        xb_q <= xb_e[IW-1:0]; yb_q <= yb_e[IW-1:0];
      end
      out_valid <= v1_q;
      if (v1_q) out_data <= pol_w[DW-1:0];
    end
  end

  // R7
  stage1_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> v1_q);
  // R7
  stage2_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) v1_q |=> out_valid);
  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n) !v1_q |=> !out_valid);
  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !en) |=> (acc_q == $past(filt_w)) && (xa_q == '0) && (yb_q == '0));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !in_valid) |=> (xa_q == '0 && ya_q == '0 && xb_q == '0 && yb_q == '0));
  // R5
  neg_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && pol && sat_w[DW-1:0] == SMIN) |=> (out_data == SMAX));
endmodule

// File: rtl/audio_hpf.sv
module audio_hpf #(
  parameter int DW = 16,
  parameter int GUARD = 2,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hpf_en,
  input  logic                 hpf_mode,
  input  logic [2:0]           cut_code,
  input  logic [2:0]           sr_code,
  input  logic                 inv_l,
  input  logic                 inv_r,
  input  logic                 l_valid_i,
  input  logic signed [DW-1:0] l_data_i,
  input  logic                 r_valid_i,
  input  logic signed [DW-1:0] r_data_i,
  output logic                 l_valid_o,
  output logic signed [DW-1:0] l_data_o,
  output logic                 r_valid_o,
  output logic signed [DW-1:0] r_data_o
);
  localparam int NCH = 2;
  localparam int CFGW = 7;

  logic [CFGW-1:0]      cfg_q;
  logic                 cfg_chg;
  logic signed [CW-1:0] k_sel;
  logic [NCH-1:0]       vin, vout, pol;
  logic signed [DW-1:0] din [NCH];
  logic signed [DW-1:0] dout [NCH];

  assign cfg_chg = {hpf_mode, cut_code, sr_code} != cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {hpf_mode, cut_code, sr_code};
  end

  hpf_coef #(.CW(CW)) u_coef (.cut(cut_code), .sr(sr_code), .k_o(k_sel));

  assign vin = {r_valid_i, l_valid_i};
  assign pol = {inv_r, inv_l};
  assign din[0] = l_data_i;
  assign din[1] = r_data_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hpf_channel #(.DW(DW), .GUARD(GUARD), .CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .in_valid(vin[c]), .in_data(din[c]),
      .en(hpf_en), .mode(hpf_mode), .k_sel(k_sel), .clr(cfg_chg), .pol(pol[c]),
      .out_valid(vout[c]), .out_data(dout[c]));
  end

  assign l_valid_o = vout[0];
  assign r_valid_o = vout[1];
  assign l_data_o  = dout[0];
  assign r_data_o  = dout[1];

  // R7
  pair_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid_i && r_valid_i) |=> ##1 (l_valid_o && r_valid_o));
  // R6
  cfg_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (cfg_q == $past({hpf_mode, cut_code, sr_code})));
endmodule

// File: tb/audio_hpf_test.sv
module audio_hpf_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, mode = 1'b0;
  logic [2:0] cut = 3'd0, sr = 3'd0;
  logic inv_l = 1'b0, inv_r = 1'b0;
  logic lv = 1'b0, rv = 1'b0;
  logic signed [15:0] ld = '0, rd = '0;
  logic lvo, rvo;
  logic signed [15:0] ldo, rdo;
  int total = 0, bad = 0;
  bit finished = 0;

  longint xa [2], ya [2], xb [2], yb [2];

  always #10 clk = ~clk;

  audio_hpf uut (.clk(clk), .rst_n(rst_n), .hpf_en(en), .hpf_mode(mode), .cut_code(cut),
    .sr_code(sr), .inv_l(inv_l), .inv_r(inv_r), .l_valid_i(lv), .l_data_i(ld),
    .r_valid_i(rv), .r_data_i(rd), .l_valid_o(lvo), .l_data_o(ldo), .r_valid_o(rvo),
    .r_data_o(rdo));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint lim(input longint v, input longint hi);
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic longint coef_sel();
    real f [8] = '{82.0, 102.0, 131.0, 163.0, 204.0, 261.0, 327.0, 408.0};
    longint w;
    int s;
    w = longint'($rtoi(f[cut] * 2.0 * 3.14159265358979 * 16384.0 / 8000.0 + 0.5));
    s = (sr[2:1] == 2'b00) ? 2 : (sr[2:1] == 2'b01) ? 1 : 0;
    return 16384 - (w >>> s);
  endfunction

  function automatic longint one_pole(input longint x, xp, yp, k);
    longint p = k * yp;
    return lim(x - xp + (p >>> 14), 131071);
  endfunction

  function automatic void clear_model();
    for (int c = 0; c < 2; c++) begin xa[c] = 0; ya[c] = 0; xb[c] = 0; yb[c] = 0; end
  endfunction

  function automatic longint model(input int c, input longint x);
    longint r, s1, s2, kk;
    bit p = (c == 0) ? inv_l : inv_r;
    if (!en) begin
      xa[c] = 0; ya[c] = 0; xb[c] = 0; yb[c] = 0; r = x;
    end else begin
      kk = coef_sel();
      s1 = one_pole(x, xa[c], ya[c], mode ? kk : 64'sd16376);
      if (mode) begin
        s2 = one_pole(s1, xb[c], yb[c], kk);
        xb[c] = s1; yb[c] = s2; r = s2;
      end else begin
        xb[c] = 0; yb[c] = 0; r = s1;
      end
      xa[c] = x; ya[c] = s1;
    end
    r = lim(r, 32767);
    if (p) r = (r == -32768) ? 32767 : -r;
    return r;
  endfunction

  task automatic set_cfg(input bit e, input bit m, input logic [2:0] c, input logic [2:0] s);
    @(negedge clk);
    if (m != mode || c != cut || s != sr) clear_model();
    en = e; mode = m; cut = c; sr = s;
    if (!e) clear_model();
    @(negedge clk);
  endtask

  task automatic send(input bit vl, input longint l, input bit vr, input longint r,
                      input string tag, output longint el, output longint er);
    @(negedge clk);
    lv = vl; rv = vr; ld = 16'(l); rd = 16'(r);
    el = vl ? model(0, l) : 0;
    er = vr ? model(1, r) : 0;
    @(negedge clk);
    lv = 0; rv = 0;
    check(!lvo && !rvo, {tag, " R7 early strobe"}, {lvo, rvo}, 0);
    @(negedge clk);
    check(lvo == vl && rvo == vr, {tag, " R7 strobe"}, {lvo, rvo}, {vl, vr});
    if (vl) check(ldo == el, {tag, " left"}, ldo, el);
    if (vr) check(rdo == er, {tag, " right"}, rdo, er);
    @(negedge clk);
    check(!lvo && !rvo, {tag, " R7 single strobe"}, {lvo, rvo}, 0);
  endtask

  task automatic t_reset();
    check(!lvo && !rvo && ldo == 0 && rdo == 0, "R8 reset outputs", ldo, 0);
  endtask

  task automatic t_bypass();
    longint el, er;
    set_cfg(0, 0, 3'd0, 3'd0);
    send(1, -32768, 1, 1234, "R1 bypass", el, er);
    check(el == -32768 && er == 1234, "R1 bypass model", el, -32768);
    send(1, 32767, 1, -7, "R1 bypass b", el, er);
  endtask

  task automatic t_polarity();
    longint el, er;
    inv_l = 1; inv_r = 0;
    send(1, -32768, 1, -32768, "R5 polarity", el, er);
    check(el == 32767, "R5 neg saturate", el, 32767);
    send(1, 1000, 1, 1000, "R5 polarity b", el, er);
    inv_l = 0; inv_r = 1;
    send(1, 250, 1, 250, "R5 polarity c", el, er);
    check(er == -250, "R5 right inverted", er, -250);
    inv_r = 0;
  endtask

  task automatic t_first_order();
    longint el, er;
    set_cfg(1, 0, 3'd0, 3'd4);
    for (int i = 0; i < 6; i++) send(1, 10000, 1, (i % 2) ? -3000 : 3000, "R2 first order", el, er);
  endtask

  task automatic t_second_order();
    longint el, er;
    set_cfg(1, 1, 3'd0, 3'd4);
    for (int i = 0; i < 5; i++) send(1, 8000, 1, i * 1500 - 4000, "R3 second order code0", el, er);
    set_cfg(1, 1, 3'd7, 3'd4);
    for (int i = 0; i < 4; i++) send(1, 8000, 1, 2000, "R3 second order code7", el, er);
  endtask

  task automatic t_groups();
    longint el, er;
    longint hi2, lo2;
    set_cfg(1, 1, 3'd5, 3'd0);
    send(1, 12000, 0, 0, "R4 group 32-48", el, er);
    send(1, 12000, 0, 0, "R4 group 32-48", hi2, er);
    set_cfg(1, 1, 3'd5, 3'd5);
    send(1, 12000, 0, 0, "R4 group 8-12", el, er);
    send(1, 12000, 0, 0, "R4 group 8-12", lo2, er);
    check(hi2 != lo2, "R4 groups differ", hi2, lo2);
    set_cfg(1, 1, 3'd3, 3'd2);
    for (int i = 0; i < 3; i++) send(1, -9000, 1, 9000, "R4 group 16-24", el, er);
  endtask

  task automatic t_clear();
    longint el, er;
    set_cfg(1, 1, 3'd2, 3'd4);
    for (int i = 0; i < 3; i++) send(1, 6000, 1, -6000, "R6 prime", el, er);
    set_cfg(1, 1, 3'd1, 3'd4);
    send(1, 500, 1, -500, "R6 after change", el, er);
    check(el == 500 && er == -500, "R6 history cleared", el, 500);
    set_cfg(1, 0, 3'd1, 3'd4);
    send(1, 700, 0, 0, "R6 after mode change", el, er);
    check(el == 700, "R6 mode change cleared", el, 700);
  endtask

  task automatic t_saturate();
    longint el, er;
    set_cfg(1, 0, 3'd2, 3'd4);
    send(1, 32767, 0, 0, "R9 sat a", el, er);
    send(1, -32768, 0, 0, "R9 sat b", el, er);
    check(el == -32768, "R9 output saturated", el, -32768);
    send(1, 32767, 0, 0, "R9 sat c", el, er);
  endtask

  task automatic t_single();
    longint el, er;
    send(0, 0, 1, 4321, "R7 right only", el, er);
    send(1, 99, 0, 0, "R7 left only", el, er);
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_polarity();
    t_first_order();
    t_second_order();
    t_groups();
    t_clear();
    t_saturate();
    t_single();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(3_000_000);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule